// File: doc/BRIEF.md
# DRAM rank power-state controller

This block decides, for a single DRAM rank, when the rank drops into a low-power mode and when it wakes up. There are three low-power modes: active power-down, precharge power-down and self-refresh. The block uses no idle timer. Every decision follows a completion event: a read response returning, a precharge finishing or a refresh finishing. A decision is taken only once nothing is in flight and nothing is waiting for the rank. Self-refresh is reached in steps. The rank first settles in precharge power-down. It wakes for a refresh. If the queues are still empty when that refresh completes, the rank goes to self-refresh.

The surrounding controller reports four things to the block: command events as they are scheduled and completed, whether any bank is open, how many reads and writes are queued for the rank, and the bus direction. In return the block issues power-down and self-refresh entry and exit commands, grants the refresh timer's request once the rank is awake, and holds a ready flag low until the programmed exit latency has elapsed. An enable input turns the whole policy off, so that the rank stays awake at all times.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: After reset the power state is awake (code 0), `rank_ready` is 1, `in_low_power` is 0, and no command output is asserted.
- R2: Low-power entry needs all of the following: `lp_en` is high, the in-flight event count (after this cycle's updates) is zero, no refresh is pending, and both queue occupancies are zero. The count goes up once for each `sched_burst`, `sched_pre` and `ref_grant` pulse, and down once for each `burst_rd_done`, `burst_wr_done`, `pre_done` and `ref_done` pulse.
- R3: A read completion (`burst_rd_done`) that meets the R2 conditions leads to active power-down (code 1) if `any_bank_open` is 1, and to precharge power-down (code 2) otherwise. `pd_enter` pulses for one cycle, in the cycle after the completion.
- R4: A precharge completion that meets the R2 conditions leads to precharge power-down if no bank is open. If a bank is still open, the completion causes no entry.
- R5: When `ref_due` is seen in either power-down state, the block issues `pd_exit`, waits out the exit latency, and then pulses `ref_grant` in the first awake cycle. `ref_grant` is only ever asserted in the awake state (code 0).
- R6: When `ref_done` arrives and the count reaches zero, the next state depends on the state before the refresh. From active power-down the rank enters precharge power-down. From precharge power-down with any queue occupied it also enters precharge power-down. From precharge power-down with both queues empty it enters self-refresh (code 3, `sr_enter` pulse). From the awake state it stays awake.
- R7: While a granted refresh has not yet completed, the event count stays at least 1, so completions in that window never cause an entry.
- R8: In either power-down state, any nonzero read or write queue occupancy causes `pd_exit`, whichever way the bus is set.
- R9: Self-refresh is left (`sr_exit`) when the read queue is nonzero, or when the write queue is nonzero and `bus_is_wr` is 1. A write queue with the bus in read mode, or `ref_due`, leaves the rank in self-refresh.
- R10: After an exit command the state is wake-up (code 4). `rank_ready` rises exactly `pd_exit_lat` cycles after the `pd_exit` cycle, or exactly `sr_exit_lat` cycles after the `sr_exit` cycle; a latency of 0 acts as 1.
- R11: While `lp_en` is 0, no entry is made. Dropping `lp_en` while in a low-power state forces the matching exit.
- R12: `in_low_power` rises in the cycle in which the entry decision is taken, one cycle before the entry command and the state change. It stays high until the rank is back in the awake state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_en | input | 1 | Enables low-power entry |
| sched_burst | input | 1 | A read/write burst was scheduled |
| sched_pre | input | 1 | A precharge was scheduled |
| burst_rd_done | input | 1 | A read burst returned its data |
| burst_wr_done | input | 1 | A write burst completed |
| pre_done | input | 1 | A precharge completed |
| ref_due | input | 1 | The refresh timer requests a refresh |
| ref_done | input | 1 | The granted refresh completed |
| any_bank_open | input | 1 | At least one bank holds an open row |
| rdq_occ | input | Q_W (6) | Read entries queued for this rank |
| wrq_occ | input | Q_W (6) | Write entries queued for this rank |
| bus_is_wr | input | 1 | Bus is currently in write direction |
| pd_exit_lat | input | LAT_W (8) | Cycles from power-down exit to ready |
| sr_exit_lat | input | LAT_W (8) | Cycles from self-refresh exit to ready |
| ref_grant | output | 1 | Refresh may be issued now |
| pd_enter | output | 1 | Power-down entry command |
| pd_exit | output | 1 | Power-down exit command |
| sr_enter | output | 1 | Self-refresh entry command |
| sr_exit | output | 1 | Self-refresh exit command |
| rank_ready | output | 1 | Rank is awake and may be accessed |
| in_low_power | output | 1 | Entry decided or rank not yet awake |
| pwr_state | output | 3 | 0 awake, 1 active PD, 2 precharge PD, 3 self-refresh, 4 waking |

## Verification
The hardest state to reach is self-refresh, because it needs a fixed sequence. The rank must settle in precharge power-down, see a refresh request, wake, receive its grant, and then report refresh completion with both queues empty. The stimulus walks that sequence one step at a time and checks each step on the way. It also varies the queue contents at the moment the refresh completes, which sends the same path to precharge power-down instead. Once the rank is in self-refresh, a write queue with the bus in read mode and a fresh refresh request are applied to show that neither wakes the rank. Only then is the bus switched to write so that the self-refresh exit latency can be timed.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

   typedef enum logic [2:0] {
      PS_ACT  = 3'd0,
      PS_APD  = 3'd1,
      PS_PPD  = 3'd2,
      PS_SREF = 3'd3,
      PS_WAKE = 3'd4
   } pwr_state_e;

endpackage

// File: rtl/rank_evt_counter.sv
// Saturating count of command events that are scheduled but not yet complete.
module rank_evt_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_burst,
   input  logic             inc_pre,
   input  logic             inc_ref,
   input  logic             dec_rd,
   input  logic             dec_wr,
   input  logic             dec_pre,
   input  logic             dec_ref,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_nxt_o
);
   localparam int SUM_W = CNT_W + 3;
   localparam int MAXV  = (1 << CNT_W) - 1;

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic [SUM_W-1:0] inc_v, dec_v, sum_v, rem_v;

   always_comb begin
      inc_v = SUM_W'(inc_burst) + SUM_W'(inc_pre) + SUM_W'(inc_ref);
      dec_v = SUM_W'(dec_rd) + SUM_W'(dec_wr) + SUM_W'(dec_pre) + SUM_W'(dec_ref);
      sum_v = SUM_W'(cnt_q) + inc_v;
      rem_v = (sum_v < dec_v) ? '0 : (sum_v - dec_v);
      if (rem_v > SUM_W'(MAXV)) cnt_nxt = CNT_W'(MAXV);
      else                      cnt_nxt = rem_v[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   assign cnt_o      = cnt_q;
   assign zero_nxt_o = (cnt_nxt == '0);
endmodule

// File: rtl/rank_exit_timer.sv
// Down-counter timing the wake-up latency; done while the count is 1 or below.
module rank_exit_timer #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LAT_W-1:0] val_i,
   output logic             done_o
);
   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - LAT_W'(1);
   end

   assign done_o = (cnt_q <= LAT_W'(1));
endmodule

// File: rtl/rank_pwr_fsm.sv
// Entry/exit decisions and the refresh-path bookkeeping.
module rank_pwr_fsm
   import rank_pwr_pkg::*;
#(
   parameter int Q_W   = 6,
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lp_en,
   input  logic             cnt_zero_nxt,
   input  logic             rd_resp_done,
   input  logic             pre_done,
   input  logic             ref_due,
   input  logic             ref_done,
   input  logic             bank_open,
   input  logic [Q_W-1:0]   rdq_occ,
   input  logic [Q_W-1:0]   wrq_occ,
   input  logic             bus_wr,
   input  logic [LAT_W-1:0] pd_lat,
   input  logic [LAT_W-1:0] sr_lat,
   input  logic             timer_done,
   output logic             timer_load,
   output logic [LAT_W-1:0] timer_val,
   output logic             ref_grant_o,
   output logic             pd_enter_o,
   output logic             pd_exit_o,
   output logic             sr_enter_o,
   output logic             sr_exit_o,
   output logic             ref_pend_o,
   output logic             in_lp_o,
   output pwr_state_e       state_o
);
   pwr_state_e state_q, state_nxt, pre_ref_q, pre_ref_nxt;
   logic wake_ref_q, wake_ref_nxt, pend_q, pend_nxt;
   logic ent_pd, ent_sr, ex_pd, ex_sr, grant;
   logic grant_q, ent_pd_q, ent_sr_q, ex_pd_q, ex_sr_q;
   logic rd_any, wr_any, q_any, idle_gate, pd_wake, sr_wake;

   always_comb begin
      rd_any    = (rdq_occ != '0);
      wr_any    = (wrq_occ != '0);
      q_any     = rd_any | wr_any;
      idle_gate = lp_en & cnt_zero_nxt & ~pend_q & ~q_any;
      pd_wake   = ~lp_en | q_any | ref_due;
      sr_wake   = ~lp_en | rd_any | (wr_any & bus_wr);
   end

   always_comb begin
      state_nxt    = state_q;
      pre_ref_nxt  = pre_ref_q;
      wake_ref_nxt = wake_ref_q;
      pend_nxt     = pend_q;
      ent_pd       = 1'b0;
      ent_sr       = 1'b0;
      ex_pd        = 1'b0;
      ex_sr        = 1'b0;
      grant        = 1'b0;
      timer_load   = 1'b0;
      timer_val    = pd_lat;
      unique case (state_q)
         PS_ACT: begin
            if (pend_q && ref_done) begin
               pend_nxt = 1'b0;
               if (lp_en && cnt_zero_nxt) begin
                  if (pre_ref_q == PS_APD) begin
                     state_nxt = PS_PPD;
                     ent_pd    = 1'b1;
                  end else if (pre_ref_q == PS_PPD) begin
                     if (q_any) begin
                        state_nxt = PS_PPD;
                        ent_pd    = 1'b1;
                     end else begin
                        state_nxt = PS_SREF;
                        ent_sr    = 1'b1;
                     end
                  end
               end
            end else if (!pend_q && ref_due) begin
               grant       = 1'b1;
               pend_nxt    = 1'b1;
               pre_ref_nxt = PS_ACT;
            end else if (idle_gate && rd_resp_done) begin
               state_nxt = bank_open ? PS_APD : PS_PPD;
               ent_pd    = 1'b1;
            end else if (idle_gate && pre_done && !bank_open) begin
               state_nxt = PS_PPD;
               ent_pd    = 1'b1;
            end
         end
         PS_APD, PS_PPD: begin
            if (pd_wake) begin
               state_nxt    = PS_WAKE;
               ex_pd        = 1'b1;
               timer_load   = 1'b1;
               timer_val    = pd_lat;
               wake_ref_nxt = ref_due;
               if (ref_due) pre_ref_nxt = state_q;
            end
         end
         PS_SREF: begin
            if (sr_wake) begin
               state_nxt    = PS_WAKE;
               ex_sr        = 1'b1;
               timer_load   = 1'b1;
               timer_val    = sr_lat;
               wake_ref_nxt = 1'b0;
            end
         end
         PS_WAKE: begin
            if (timer_done) begin
               state_nxt = PS_ACT;
               if (wake_ref_q) begin
                  grant        = 1'b1;
                  pend_nxt     = 1'b1;
                  wake_ref_nxt = 1'b0;
               end
            end
         end
         default: state_nxt = PS_ACT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PS_ACT;
         pre_ref_q  <= PS_ACT;
         wake_ref_q <= 1'b0;
         pend_q     <= 1'b0;
         grant_q    <= 1'b0;
         ent_pd_q   <= 1'b0;
         ent_sr_q   <= 1'b0;
         ex_pd_q    <= 1'b0;
         ex_sr_q    <= 1'b0;
      end else begin
         state_q    <= state_nxt;
         pre_ref_q  <= pre_ref_nxt;
         wake_ref_q <= wake_ref_nxt;
         pend_q     <= pend_nxt;
         grant_q    <= grant;
         ent_pd_q   <= ent_pd;
         ent_sr_q   <= ent_sr;
         ex_pd_q    <= ex_pd;
         ex_sr_q    <= ex_sr;
      end
   end

   assign ref_grant_o = grant_q;
   assign pd_enter_o  = ent_pd_q;
   assign sr_enter_o  = ent_sr_q;
   assign pd_exit_o   = ex_pd_q;
   assign sr_exit_o   = ex_sr_q;
   assign ref_pend_o  = pend_q;
   assign in_lp_o     = ent_pd | ent_sr | (state_q != PS_ACT);
   assign state_o     = state_q;
endmodule

// File: rtl/rank_pwr_ctrl.sv
module rank_pwr_ctrl
   import rank_pwr_pkg::*;
#(
   parameter int Q_W   = 6,
   parameter int LAT_W = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lp_en,
   input  logic             sched_burst,
   input  logic             sched_pre,
   input  logic             burst_rd_done,
   input  logic             burst_wr_done,
   input  logic             pre_done,
   input  logic             ref_due,
   input  logic             ref_done,
   input  logic             any_bank_open,
   input  logic [Q_W-1:0]   rdq_occ,
   input  logic [Q_W-1:0]   wrq_occ,
   input  logic             bus_is_wr,
   input  logic [LAT_W-1:0] pd_exit_lat,
   input  logic [LAT_W-1:0] sr_exit_lat,
   output logic             ref_grant,
   output logic             pd_enter,
   output logic             pd_exit,
   output logic             sr_enter,
   output logic             sr_exit,
   output logic             rank_ready,
   output logic             in_low_power,
   output logic [2:0]       pwr_state
);
   initial begin
      assert (Q_W >= 1)   else $error("Q_W must be at least 1");
      assert (LAT_W >= 2) else $error("LAT_W must be at least 2");
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] evt_cnt;
   logic             cnt_zero_nxt;
   logic             ref_pend;
   logic             tmr_load, tmr_done;
   logic [LAT_W-1:0] tmr_val;
   pwr_state_e       st;

   rank_evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_burst  (sched_burst),
      .inc_pre    (sched_pre),
      .inc_ref    (ref_grant),
      .dec_rd     (burst_rd_done),
      .dec_wr     (burst_wr_done),
      .dec_pre    (pre_done),
      .dec_ref    (ref_done),
      .cnt_o      (evt_cnt),
      .zero_nxt_o (cnt_zero_nxt)
   );

   rank_exit_timer #(.LAT_W(LAT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .done_o (tmr_done)
   );

   rank_pwr_fsm #(.Q_W(Q_W), .LAT_W(LAT_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .lp_en        (lp_en),
      .cnt_zero_nxt (cnt_zero_nxt),
      .rd_resp_done (burst_rd_done),
      .pre_done     (pre_done),
      .ref_due      (ref_due),
      .ref_done     (ref_done),
      .bank_open    (any_bank_open),
      .rdq_occ      (rdq_occ),
      .wrq_occ      (wrq_occ),
      .bus_wr       (bus_is_wr),
      .pd_lat       (pd_exit_lat),
      .sr_lat       (sr_exit_lat),
      .timer_done   (tmr_done),
      .timer_load   (tmr_load),
      .timer_val    (tmr_val),
      .ref_grant_o  (ref_grant),
      .pd_enter_o   (pd_enter),
      .pd_exit_o    (pd_exit),
      .sr_enter_o   (sr_enter),
      .sr_exit_o    (sr_exit),
      .ref_pend_o   (ref_pend),
      .in_lp_o      (in_low_power),
      .state_o      (st)
   );

   assign pwr_state  = st;
   assign rank_ready = (st == PS_ACT);
endmodule

// File: rtl/rank_pwr_ctrl_chk.sv
module rank_pwr_ctrl_chk #(
   parameter int Q_W   = 6,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lp_en,
   input logic [Q_W-1:0]   rdq_occ,
   input logic [Q_W-1:0]   wrq_occ,
   input logic             bus_is_wr,
   input logic             ref_grant,
   input logic             pd_enter,
   input logic             pd_exit,
   input logic             sr_enter,
   input logic             sr_exit,
   input logic             rank_ready,
   input logic             in_low_power,
   input logic [2:0]       pwr_state,
   input logic [CNT_W-1:0] evt_cnt,
   input logic             ref_pend
);
   a_r2_entry_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_enter || sr_enter) |-> $past(lp_en));

   a_r2_entry_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_enter || sr_enter) |-> (evt_cnt == '0));

   a_r7_ref_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pend && !ref_grant) |-> (evt_cnt != '0));

   a_r5_grant_when_awake: assert property (@(posedge clk) disable iff (!rst_n)
      ref_grant |-> (pwr_state == 3'd0));

   a_r9_sr_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
      sr_exit |-> $past(!lp_en || (rdq_occ != '0) || ((wrq_occ != '0) && bus_is_wr)));

   a_r10_not_ready_at_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_exit || sr_exit) |-> !rank_ready);

   a_r12_lp_covers_state: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state != 3'd0) |-> in_low_power);

   a_r12_lp_leads_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_enter || sr_enter) |-> $past(in_low_power));

   a_r1_one_command: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ref_grant, pd_enter, pd_exit, sr_enter, sr_exit}));
endmodule

bind rank_pwr_ctrl rank_pwr_ctrl_chk #(.Q_W(Q_W), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lp_en        (lp_en),
   .rdq_occ      (rdq_occ),
   .wrq_occ      (wrq_occ),
   .bus_is_wr    (bus_is_wr),
   .ref_grant    (ref_grant),
   .pd_enter     (pd_enter),
   .pd_exit      (pd_exit),
   .sr_enter     (sr_enter),
   .sr_exit      (sr_exit),
   .rank_ready   (rank_ready),
   .in_low_power (in_low_power),
   .pwr_state    (pwr_state),
   .evt_cnt      (evt_cnt),
   .ref_pend     (ref_pend)
);

// File: tb/rank_pwr_ctrl_tb_top.sv
`timescale 1ns/100ps
module rank_pwr_ctrl_tb_top;
   localparam int Q_W = 6;
   localparam int LAT_W = 8;
   localparam int PD_L = 3;
   localparam int SR_L = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lp_en = 1'b1;
   logic sched_burst = 1'b0, sched_pre = 1'b0;
   logic burst_rd_done = 1'b0, burst_wr_done = 1'b0, pre_done = 1'b0;
   logic ref_due = 1'b0, ref_done = 1'b0, any_bank_open = 1'b0, bus_is_wr = 1'b0;
   logic [Q_W-1:0] rdq_occ = '0, wrq_occ = '0;
   logic [LAT_W-1:0] pd_exit_lat = LAT_W'(PD_L), sr_exit_lat = LAT_W'(SR_L);
   logic ref_grant, pd_enter, pd_exit, sr_enter, sr_exit, rank_ready, in_low_power;
   logic [2:0] pwr_state;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rank_pwr_ctrl #(.Q_W(Q_W), .LAT_W(LAT_W), .CNT_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .lp_en(lp_en), .sched_burst(sched_burst),
      .sched_pre(sched_pre), .burst_rd_done(burst_rd_done), .burst_wr_done(burst_wr_done),
      .pre_done(pre_done), .ref_due(ref_due), .ref_done(ref_done),
      .any_bank_open(any_bank_open), .rdq_occ(rdq_occ), .wrq_occ(wrq_occ),
      .bus_is_wr(bus_is_wr), .pd_exit_lat(pd_exit_lat), .sr_exit_lat(sr_exit_lat),
      .ref_grant(ref_grant), .pd_enter(pd_enter), .pd_exit(pd_exit),
      .sr_enter(sr_enter), .sr_exit(sr_exit), .rank_ready(rank_ready),
      .in_low_power(in_low_power), .pwr_state(pwr_state));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; lp_en = 1'b1; sched_burst = 0; sched_pre = 0;
      burst_rd_done = 0; burst_wr_done = 0; pre_done = 0; ref_due = 0; ref_done = 0;
      any_bank_open = 0; bus_is_wr = 0; rdq_occ = '0; wrq_occ = '0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic one_burst();
      sched_burst = 1; step(); sched_burst = 0;
   endtask

   task automatic rd_complete();
      burst_rd_done = 1; step(); burst_rd_done = 0;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!rank_ready && n < 500) begin
         step();
         n++;
      end
   endtask

   task automatic enter_pd(input logic open);
      any_bank_open = open;
      one_burst();
      rd_complete();
      step();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 state", pwr_state, 0);
      chk("R1 ready", rank_ready, 1);
      chk("R1 in_low_power", in_low_power, 0);
      chk("R1 commands", {ref_grant, pd_enter, pd_exit, sr_enter, sr_exit}, 0);
   endtask

   task automatic t_rd_entry();
      do_reset();
      any_bank_open = 1;
      one_burst();
      burst_rd_done = 1; #1;
      chk("R12 in_low_power at decision", in_low_power, 1);
      chk("R12 state not yet changed", pwr_state, 0);
      step(); burst_rd_done = 0;
      chk("R3 pd_enter", pd_enter, 1);
      chk("R3 active power-down", pwr_state, 1);
      step();
      chk("R3 pd_enter single pulse", pd_enter, 0);
      chk("R12 in_low_power resident", in_low_power, 1);
      do_reset();
      enter_pd(1'b0);
      chk("R3 precharge power-down", pwr_state, 2);
   endtask

   task automatic t_counter();
      do_reset();
      one_burst(); one_burst();
      rd_complete();
      chk("R2 outstanding burst blocks", pwr_state, 0);
      rd_complete();
      chk("R2 entry when count reaches zero", pwr_state, 2);
      do_reset();
      one_burst();
      rdq_occ = 1;
      rd_complete();
      chk("R2 queued read blocks entry", pwr_state, 0);
      chk("R2 no pd_enter with queue", pd_enter, 0);
   endtask

   task automatic t_pre_entry();
      do_reset();
      any_bank_open = 1;
      sched_pre = 1; step(); sched_pre = 0;
      pre_done = 1; step(); pre_done = 0;
      chk("R4 bank open no entry", pwr_state, 0);
      any_bank_open = 0;
      sched_pre = 1; step(); sched_pre = 0;
      pre_done = 1; step(); pre_done = 0;
      chk("R4 precharge entry", pwr_state, 2);
      chk("R4 pd_enter", pd_enter, 1);
   endtask

   task automatic t_pd_exit();
      int n;
      do_reset();
      enter_pd(1'b0);
      wrq_occ = 2; bus_is_wr = 0;
      step();
      chk("R8 write queue wakes regardless of bus", pd_exit, 1);
      chk("R10 waking state", pwr_state, 4);
      chk("R10 not ready", rank_ready, 0);
      wait_ready(n);
      chk("R10 power-down exit latency", n, PD_L);
   endtask

   task automatic t_ref_sr();
      int n;
      do_reset();
      enter_pd(1'b0);
      ref_due = 1;
      step();
      chk("R5 pd_exit before refresh", pd_exit, 1);
      chk("R5 no early grant", ref_grant, 0);
      wait_ready(n);
      chk("R5 wake latency", n, PD_L);
      chk("R5 grant on wake", ref_grant, 1);
      ref_due = 0;
      step(); step();
      ref_done = 1; step(); ref_done = 0;
      chk("R6 self-refresh entry", sr_enter, 1);
      chk("R6 self-refresh state", pwr_state, 3);
      wrq_occ = 1; bus_is_wr = 0; ref_due = 1;
      step(); step(); step();
      chk("R9 stays in self-refresh", pwr_state, 3);
      chk("R9 ref_due ignored", ref_grant | pd_exit | sr_exit, 0);
      ref_due = 0; bus_is_wr = 1;
      step();
      chk("R9 sr_exit on write with bus write", sr_exit, 1);
      wait_ready(n);
      chk("R10 self-refresh exit latency", n, SR_L);
   endtask

   task automatic t_ref_apd();
      int n;
      do_reset();
      enter_pd(1'b1);
      chk("R6 start in active power-down", pwr_state, 1);
      ref_due = 1; step();
      wait_ready(n);
      ref_due = 0;
      step();
      ref_done = 1; step(); ref_done = 0;
      chk("R6 from active PD goes to precharge PD", pwr_state, 2);
      chk("R6 pd_enter after refresh", pd_enter, 1);
   endtask

   task automatic t_ref_queued();
      int n;
      do_reset();
      enter_pd(1'b0);
      ref_due = 1; step();
      wait_ready(n);
      ref_due = 0;
      step();
      wrq_occ = 1; bus_is_wr = 0;
      ref_done = 1; step(); ref_done = 0;
      chk("R6 queued after refresh gives precharge PD", pwr_state, 2);
      step();
      chk("R8 then wakes for queued write", pd_exit, 1);
   endtask

   task automatic t_ref_pending();
      do_reset();
      ref_due = 1; step(); ref_due = 0;
      chk("R7 direct grant while awake", ref_grant, 1);
      one_burst();
      burst_rd_done = 1; #1;
      chk("R7 no decision while refresh pending", in_low_power, 0);
      step(); burst_rd_done = 0;
      chk("R7 no entry while refresh pending", pwr_state, 0);
      ref_done = 1; step(); ref_done = 0;
      chk("R6 refresh from awake stays awake", pwr_state, 0);
      chk("R6 no entry command", pd_enter | sr_enter, 0);
   endtask

   task automatic t_disable();
      do_reset();
      lp_en = 0;
      enter_pd(1'b0);
      chk("R11 disabled no entry", pwr_state, 0);
      lp_en = 1;
      enter_pd(1'b0);
      chk("R11 enabled entry", pwr_state, 2);
      lp_en = 0;
      step();
      chk("R11 disable forces exit", pd_exit, 1);
   endtask

   initial begin
      t_reset();
      t_rd_entry();
      t_counter();
      t_pre_entry();
      t_pd_exit();
      t_ref_sr();
      t_ref_apd();
      t_ref_queued();
      t_ref_pending();
      t_disable();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule